// File: doc/BRIEF.md
# Redistributor Frame Address Decoder

This block sits behind the bus port that serves the per-processor redistributor region of an interrupt controller. Every processor owns a pair of 64 KB frames. The pair for processor c starts at `BASE_ADDR + c * 128 KB`. The lower frame of the pair holds control, identification, type and table-base words. The upper frame holds the processor's private-interrupt registers.

For each request the block works out which processor and which frame the address belongs to. It answers the read-only words itself. The type word is built on the fly from the target processor's 24-bit affinity value, its index and a flag that marks the highest-numbered processor. Requests that land on the private-interrupt state raise a select output, so that the storage kept elsewhere can serve them. Addresses outside the window raise a miss flag.

Responses are registered and come back one cycle after the request. Writes never change anything the block reports.

Top module: `redist_frame_decoder`

## Requirements
- R1: A request accepted on a rising edge produces `rsp_valid_o` after that same edge. `rsp_cpu_o` gives `(addr - BASE_ADDR) >> 17`. `rsp_frame_o` gives bit 16 of `addr - BASE_ADDR` (0 = lower frame, 1 = upper frame). The last word of the window still decodes to processor N-1 in its upper frame.
- R2: An address below `BASE_ADDR`, or at or above `BASE_ADDR + N_CPU * 128 KB`, sets `rsp_miss_o`. In that case data, processor, frame and select outputs are all zero.
- R3: The 64-bit type word at lower-frame offset 0x0008 holds the following fields. The target's affinity[23:0] is at bits [55:32]. The 16-bit processor index is at bits [23:8]. The last-processor flag is at bit 4. All other bits are zero.
- R4: The last-processor flag is set only when the processor index equals N_CPU-1.
- R5: `req_size_i` selects the access width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Read data is the 8-byte word at `addr & ~7`, shifted right by `addr[2:0]` bytes and masked to the access width. An 8-bit or 16-bit read of the type word returns zero.
- R6: Three lower-frame words read as zero: the control word at 0x0000 and the two table-base words at 0x0070 and 0x0078. A write returns zero data, and later reads return the same value as before the write.
- R7: In the lower frame, the identification word at offset 0xFFE8 reads 0x3B. Every other offset of the identification page (0xFFD0 to 0xFFFC) reads zero. The same offsets in the upper frame read zero.
- R8: In the upper frame, the group word at 0x0080 reads 0xFFFFFFFF. The group-modifier word at 0x0D00 and the access-control word at 0x0E00 read zero.
- R9: An upper-frame offset from 0x0100 up to but not including 0x0C08 asserts `priv_sel_o`, for reads and for writes alike, with zero data from this block. Offsets 0x00FC and 0x0C08 do not assert it.
- R10: Under reset, and in any cycle after a cycle without a request, `rsp_valid_o`, `rsp_data_o` and `priv_sel_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Access width code (R5) |
| cpu_aff_i | input | N_CPU*24 | Affinity of processor c at bits [c*24 +: 24] |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_miss_o | output | 1 | Address outside the redistributor window |
| rsp_data_o | output | 64 | Read data, lane-aligned to address |
| rsp_cpu_o | output | CPU_W | Decoded processor index |
| rsp_frame_o | output | 1 | Decoded frame within the pair |
| priv_sel_o | output | 1 | Request targets private-interrupt state |

## Verification
The assertions assume that `BASE_ADDR` is a multiple of 128 KB, so that the low address bits equal the in-frame offset. They also assume that `cpu_aff_i` only changes while no request is in flight. The stimulus holds the affinity vector constant for the whole run. It changes inputs only on falling edges, and it uses base-aligned addresses with accesses that are naturally aligned to their width. The window edges are reached from both sides: one word below the base, the last word of the window, and the first byte beyond it.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

    localparam int FRAME_BITS = 16;
    localparam int PAIR_BITS  = 17;
    localparam int IDX_W      = 4;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } acc_size_e;

    // 8-byte word indices (offset >> 3) inside a frame
    localparam logic [12:0] DW_TYPE  = 13'h0001;
    localparam logic [12:0] DW_ID2   = 13'h1FFD;
    localparam logic [12:0] DW_GROUP = 13'h0010;

    localparam logic [15:0] PRIV_LO  = 16'h0100;
    localparam logic [15:0] PRIV_END = 16'h0C08;

    localparam logic [31:0] ID2_VALUE = 32'h0000_003B;
    localparam int          LAST_BIT  = 4;

    typedef struct packed {
        logic             miss;
        logic [IDX_W-1:0] cpu;
        logic             frame;
        logic [15:0]      off;
    } frame_dec_t;

    typedef struct packed {
        logic [63:0] dword;
        logic        is_type;
        logic        priv;
    } reg_view_t;

    function automatic logic [63:0] type_word(input logic [23:0] aff,
                                              input logic [15:0] idx,
                                              input logic        last);
        logic [63:0] w;
        w           = '0;
        w[55:32]    = aff;
        w[23:8]     = idx;
        w[LAST_BIT] = last;
        return w;
    endfunction

    function automatic logic [63:0] lane_extract(input logic [63:0] v,
                                                 input logic [2:0]  lane,
                                                 input acc_size_e   sz);
        logic [63:0] sh;
        sh = v >> {lane, 3'b000};
        case (sz)
            SZ_8:    return {56'h0, sh[7:0]};
            SZ_16:   return {48'h0, sh[15:0]};
            SZ_32:   return {32'h0, sh[31:0]};
            default: return sh;
        endcase
    endfunction

endpackage

// File: rtl/rdf_addr_decode.sv
module rdf_addr_decode
    import rdf_pkg::*;
#(
    parameter int                N_CPU     = 4,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0A00_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output frame_dec_t        dec
);
    localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(N_CPU * (1 << PAIR_BITS));

    logic [ADDR_W-1:0] rel;
    logic              below;
    logic              beyond;

    always_comb begin
        rel       = addr - BASE_ADDR;
        below     = addr < BASE_ADDR;
        beyond    = {1'b0, rel} >= SPAN;
        dec.miss  = below || beyond;
        dec.cpu   = rel[PAIR_BITS +: IDX_W];
        dec.frame = rel[FRAME_BITS];
        dec.off   = rel[FRAME_BITS-1:0];
    end
endmodule

// File: rtl/rdf_reg_view.sv
module rdf_reg_view
    import rdf_pkg::*;
#(
    parameter int N_CPU = 4
) (
    input  frame_dec_t        dec,
    input  logic [N_CPU*24-1:0] cpu_aff,
    output reg_view_t         view
);
    logic [23:0] aff_sel;
    logic        is_last;
    logic [12:0] dw;

    always_comb begin
        aff_sel = '0;
        for (int c = 0; c < N_CPU; c++) begin
            if (dec.cpu == IDX_W'(c)) aff_sel = cpu_aff[c*24 +: 24];
        end
    end

    always_comb begin
        is_last      = dec.cpu == IDX_W'(N_CPU - 1);
        dw           = dec.off[15:3];
        view.dword   = '0;
        view.is_type = 1'b0;
        view.priv    = 1'b0;
        if (!dec.frame) begin
            if (dw == DW_TYPE) begin
                view.dword   = type_word(aff_sel, 16'(dec.cpu), is_last);
                view.is_type = 1'b1;
            end else if (dw == DW_ID2) begin
                view.dword = {32'h0, ID2_VALUE};
            end
        end else begin
            if (dw == DW_GROUP) begin
                view.dword = {32'h0, 32'hFFFF_FFFF};
            end
            view.priv = (dec.off >= PRIV_LO) && (dec.off < PRIV_END);
        end
    end
endmodule

// File: rtl/redist_frame_decoder.sv
module redist_frame_decoder
    import rdf_pkg::*;
#(
    parameter int                N_CPU     = 4,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0A00_0000,
    localparam int               CPU_W     = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [1:0]          req_size_i,
    input  logic [N_CPU*24-1:0] cpu_aff_i,
    output logic                rsp_valid_o,
    output logic                rsp_miss_o,
    output logic [63:0]         rsp_data_o,
    output logic [CPU_W-1:0]    rsp_cpu_o,
    output logic                rsp_frame_o,
    output logic                priv_sel_o
);
    frame_dec_t  dec;
    reg_view_t   view;
    acc_size_e   size;
    logic        narrow;
    logic        hit;
    logic [63:0] lane_data;
    logic [63:0] next_data;

    rdf_addr_decode #(
        .N_CPU(N_CPU), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr(req_addr_i),
        .dec (dec)
    );

    rdf_reg_view #(.N_CPU(N_CPU)) u_view (
        .dec    (dec),
        .cpu_aff(cpu_aff_i),
        .view   (view)
    );

    always_comb begin
        size      = acc_size_e'(req_size_i);
        narrow    = (size == SZ_8) || (size == SZ_16);
        hit       = req_valid_i && !dec.miss;
        lane_data = (view.is_type && narrow) ? 64'h0
                  : lane_extract(view.dword, dec.off[2:0], size);
        next_data = (hit && !req_write_i) ? lane_data : 64'h0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_miss_o  <= 1'b0;
            rsp_data_o  <= '0;
            rsp_cpu_o   <= '0;
            rsp_frame_o <= 1'b0;
            priv_sel_o  <= 1'b0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_miss_o  <= req_valid_i && dec.miss;
            rsp_data_o  <= next_data;
            rsp_cpu_o   <= hit ? dec.cpu[CPU_W-1:0] : '0;
            rsp_frame_o <= hit && dec.frame;
            priv_sel_o  <= hit && view.priv;
        end
    end
endmodule

// File: rtl/rdf_checker.sv
module rdf_checker #(
    parameter int                N_CPU     = 4,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0A00_0000,
    localparam int               CPU_W     = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid_i,
    input logic                req_write_i,
    input logic [ADDR_W-1:0]   req_addr_i,
    input logic [1:0]          req_size_i,
    input logic                rsp_valid_o,
    input logic                rsp_miss_o,
    input logic [63:0]         rsp_data_o,
    input logic [CPU_W-1:0]    rsp_cpu_o,
    input logic                rsp_frame_o,
    input logic                priv_sel_o
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> rsp_valid_o); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!rsp_valid_o && rsp_data_o == 64'h0 && !priv_sel_o)); // R10

    AST_MISS_ZEROES: assert property (@(posedge clk) disable iff (rst)
        rsp_miss_o |-> (rsp_data_o == 64'h0 && !priv_sel_o && rsp_cpu_o == '0 && !rsp_frame_o)); // R2

    AST_BELOW_BASE_MISS: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_addr_i < BASE_ADDR) |=> rsp_miss_o); // R2

    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_write_i) |=> rsp_data_o == 64'h0); // R6

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_size_i != 2'd3) |=> rsp_data_o[63:32] == 32'h0); // R5

    AST_PRIV_UPPER_FRAME: assert property (@(posedge clk) disable iff (rst)
        priv_sel_o |-> (rsp_frame_o && !rsp_miss_o && rsp_data_o == 64'h0)); // R9
endmodule

bind redist_frame_decoder rdf_checker #(
    .N_CPU(N_CPU), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_size_i (req_size_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_miss_o (rsp_miss_o),
    .rsp_data_o (rsp_data_o),
    .rsp_cpu_o  (rsp_cpu_o),
    .rsp_frame_o(rsp_frame_o),
    .priv_sel_o (priv_sel_o)
);

// File: tb/redist_frame_decoder_tb.sv
module redist_frame_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_CPU      = 4;
    localparam int WD_CYCLES  = 5000;
    localparam int NV         = 25;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [1:0]  sz;
        logic [63:0] data;
        logic        miss;
        logic [1:0]  cpu;
        logic        frame;
        logic        priv;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0A02_0008, 2'd3, 64'h0011_1213_0000_0100, 1'b0, 2'd1, 1'b0, 1'b0, 4'd3}, // R3
        '{1'b0, 32'h0A06_0008, 2'd3, 64'h0031_3233_0000_0310, 1'b0, 2'd3, 1'b0, 1'b0, 4'd4}, // R4
        '{1'b0, 32'h0A04_0008, 2'd2, 64'h0000_0000_0000_0200, 1'b0, 2'd2, 1'b0, 1'b0, 4'd4}, // R4
        '{1'b0, 32'h0A04_000C, 2'd2, 64'h0000_0000_0021_2223, 1'b0, 2'd2, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b0, 32'h0A02_0009, 2'd0, 64'h0,                   1'b0, 2'd1, 1'b0, 1'b0, 4'd5}, // R5
        '{1'b0, 32'h0A03_0082, 2'd1, 64'h0000_0000_0000_FFFF, 1'b0, 2'd1, 1'b1, 1'b0, 4'd5}, // R5
        '{1'b0, 32'h0A00_0000, 2'd2, 64'h0,                   1'b0, 2'd0, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b0, 32'h0A06_0070, 2'd3, 64'h0,                   1'b0, 2'd3, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b1, 32'h0A02_0008, 2'd3, 64'h0,                   1'b0, 2'd1, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b0, 32'h0A02_0008, 2'd3, 64'h0011_1213_0000_0100, 1'b0, 2'd1, 1'b0, 1'b0, 4'd6}, // R6
        '{1'b0, 32'h0A02_FFE8, 2'd2, 64'h0000_0000_0000_003B, 1'b0, 2'd1, 1'b0, 1'b0, 4'd7}, // R7
        '{1'b0, 32'h0A02_FFEC, 2'd2, 64'h0,                   1'b0, 2'd1, 1'b0, 1'b0, 4'd7}, // R7
        '{1'b0, 32'h0A00_FFE0, 2'd2, 64'h0,                   1'b0, 2'd0, 1'b0, 1'b0, 4'd7}, // R7
        '{1'b0, 32'h0A03_FFE8, 2'd2, 64'h0,                   1'b0, 2'd1, 1'b1, 1'b0, 4'd7}, // R7
        '{1'b0, 32'h0A03_0080, 2'd2, 64'h0000_0000_FFFF_FFFF, 1'b0, 2'd1, 1'b1, 1'b0, 4'd8}, // R8
        '{1'b0, 32'h0A03_0D00, 2'd2, 64'h0,                   1'b0, 2'd1, 1'b1, 1'b0, 4'd8}, // R8
        '{1'b0, 32'h0A07_0E00, 2'd2, 64'h0,                   1'b0, 2'd3, 1'b1, 1'b0, 4'd8}, // R8
        '{1'b0, 32'h0A05_0100, 2'd2, 64'h0,                   1'b0, 2'd2, 1'b1, 1'b1, 4'd9}, // R9
        '{1'b0, 32'h0A01_0C04, 2'd2, 64'h0,                   1'b0, 2'd0, 1'b1, 1'b1, 4'd9}, // R9
        '{1'b0, 32'h0A01_0C08, 2'd2, 64'h0,                   1'b0, 2'd0, 1'b1, 1'b0, 4'd9}, // R9
        '{1'b0, 32'h0A01_00FC, 2'd2, 64'h0,                   1'b0, 2'd0, 1'b1, 1'b0, 4'd9}, // R9
        '{1'b1, 32'h0A05_0200, 2'd2, 64'h0,                   1'b0, 2'd2, 1'b1, 1'b1, 4'd9}, // R9
        '{1'b0, 32'h09FF_FFFC, 2'd2, 64'h0,                   1'b1, 2'd0, 1'b0, 1'b0, 4'd2}, // R2
        '{1'b0, 32'h0A08_0000, 2'd2, 64'h0,                   1'b1, 2'd0, 1'b0, 1'b0, 4'd2}, // R2
        '{1'b0, 32'h0A07_FFFC, 2'd2, 64'h0,                   1'b0, 2'd3, 1'b1, 1'b0, 4'd1}  // R1
    };

    logic                clk = 1'b0;
    logic                rst;
    logic                req_valid_i;
    logic                req_write_i;
    logic [31:0]         req_addr_i;
    logic [1:0]          req_size_i;
    logic [N_CPU*24-1:0] cpu_aff_i;
    logic                rsp_valid_o;
    logic                rsp_miss_o;
    logic [63:0]         rsp_data_o;
    logic [1:0]          rsp_cpu_o;
    logic                rsp_frame_o;
    logic                priv_sel_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    redist_frame_decoder #(.N_CPU(N_CPU)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid_i(req_valid_i),
        .req_write_i(req_write_i),
        .req_addr_i (req_addr_i),
        .req_size_i (req_size_i),
        .cpu_aff_i  (cpu_aff_i),
        .rsp_valid_o(rsp_valid_o),
        .rsp_miss_o (rsp_miss_o),
        .rsp_data_o (rsp_data_o),
        .rsp_cpu_o  (rsp_cpu_o),
        .rsp_frame_o(rsp_frame_o),
        .priv_sel_o (priv_sel_o)
    );

    task automatic check_quiet(input string tag);
        checks++;
        if (rsp_valid_o !== 1'b0 || rsp_data_o !== 64'h0 || priv_sel_o !== 1'b0) begin
            errors++;
            $display("FAIL %s: valid=%b data=%h priv=%b expected valid=0 data=0 priv=0",
                     tag, rsp_valid_o, rsp_data_o, priv_sel_o);
        end
    endtask

    initial begin
        rst         = 1'b1;
        req_valid_i = 1'b0;
        req_write_i = 1'b0;
        req_addr_i  = '0;
        req_size_i  = 2'd2;
        cpu_aff_i   = {24'h313233, 24'h212223, 24'h111213, 24'h010203};
        repeat (3) @(negedge clk);
        check_quiet("R10 reset state");
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            req_valid_i = 1'b1;
            req_write_i = VECS[i].wr;
            req_addr_i  = VECS[i].addr;
            req_size_i  = VECS[i].sz;
            @(negedge clk);
            checks++;
            if (rsp_valid_o !== 1'b1 || rsp_data_o !== VECS[i].data ||
                rsp_miss_o !== VECS[i].miss || rsp_cpu_o !== VECS[i].cpu ||
                rsp_frame_o !== VECS[i].frame || priv_sel_o !== VECS[i].priv) begin
                errors++;
                $display("FAIL R%0d vec %0d addr=%h: v=%b d=%h m=%b c=%0d f=%b p=%b expected v=1 d=%h m=%b c=%0d f=%b p=%b",
                         VECS[i].req, i, VECS[i].addr, rsp_valid_o, rsp_data_o,
                         rsp_miss_o, rsp_cpu_o, rsp_frame_o, priv_sel_o,
                         VECS[i].data, VECS[i].miss, VECS[i].cpu,
                         VECS[i].frame, VECS[i].priv);
            end
        end

        // R10: idle cycle after a request
        req_valid_i = 1'b0;
        @(negedge clk);
        check_quiet("R10 idle after request");

        // R1: response appears only after the capturing edge
        req_valid_i = 1'b1;
        req_write_i = 1'b0;
        req_addr_i  = 32'h0A06_0008;
        req_size_i  = 2'd3;
        #1;
        check_quiet("R1 no response before edge");
        @(negedge clk);
        checks++;
        if (rsp_valid_o !== 1'b1 || rsp_data_o !== 64'h0031_3233_0000_0310) begin
            errors++;
            $display("FAIL R1 latency: valid=%b data=%h expected valid=1 data=%h",
                     rsp_valid_o, rsp_data_o, 64'h0031_3233_0000_0310);
        end

        // R10: reset in mid-traffic clears the response
        rst = 1'b1;
        @(negedge clk);
        check_quiet("R10 reset during traffic");
        rst         = 1'b0;
        req_valid_i = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule